// File: doc/BRIEF.md
# Six-Channel Short-Sync Serial Audio Receiver

This block deserialises a short-frame-sync serial audio stream that carries three stereo pairs per sample period. It runs on the serial bit clock. It samples the sync and data lines on each rising edge. After a sync it collects six words back to back, most significant bit first, in a fixed interleaved order: pair 1 left, pair 1 right, pair 2 left, pair 2 right, pair 3 left, pair 3 right. No spare bit clocks stand between the words.

The word length comes from a two-bit code, and each received word is left-justified in a 32-bit slot. A mode input sets when the first bit is taken. It is either on the same edge that first sees the sync high, or one edge later. When the sixth word is complete, all six slots update at once and a one-cycle strobe marks the new frame. Data after the sixth word is discarded. A sync that comes before a frame is finished sets a sticky error flag and starts the frame again.

Top module: `srx_dsp_rx`

## Requirements
- R1: While and after reset, `frame_vld_o` and `sync_err_o` are 0 and every slot of `words_o` is zero.
- R2: Word k of a frame goes to `words_o[k*32 +: 32]`, with k=0 pair 1 left, 1 pair 1 right, 2 pair 2 left, 3 pair 2 right, 4 pair 3 left, 5 pair 3 right. Each word's first bit directly follows the previous word's last bit.
- R3: Words arrive MSB first. `cfg_wlen_i` sets the length: 0=16, 1=20, 2=24, 3=32 bits. Each word is left-justified in its slot, and the unused low bits are zero.
- R4: With `cfg_mode_b_i`=1, the first data bit is sampled on the same rising edge on which `fsync_i` is first seen high.
- R5: With `cfg_mode_b_i`=0, the first data bit is sampled on the rising edge after the one on which `fsync_i` is first seen high. The line value at the sync edge is ignored.
- R6: `frame_vld_o` is high for exactly one cycle, the cycle after the edge that samples the last bit of word 5. It is low during reception. `words_o` changes only in a cycle in which `frame_vld_o` is high.
- R7: Bits after word 5 and before the next sync leave `words_o` unchanged and raise no strobe.
- R8: A rising `fsync_i` seen before word 5 is complete sets `sync_err_o` from the next cycle. The partial frame is never published, and reception restarts at word 0 from that sync.
- R9: Once set, `sync_err_o` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_b_i | input | 1 | 1: first bit on the sync edge; 0: one edge later |
| cfg_wlen_i | input | 2 | Word length code (16/20/24/32) |
| fsync_i | input | 1 | Frame sync; its rising edge starts a frame |
| sdata_i | input | 1 | Serial data, MSB first |
| words_o | output | 192 | Six left-justified 32-bit slots |
| frame_vld_o | output | 1 | One-cycle new-frame strobe |
| sync_err_o | output | 1 | Sticky early-sync error flag |

## Verification
The bound checker watches four properties on every cycle. The strobe never lasts two cycles. The output slots never change without the strobe. The error flag never clears before reset. The flag only rises right after an edge that saw the sync high.

Only the bench scenarios can show the rest, because it depends on a whole serial frame. That covers bit order, word placement, left-justification at each length, the one-edge difference between the two sync modes, discarding of trailing bits, and a clean restart after an early sync.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RECV  = 2'd2
    } srx_state_e;

    function automatic int unsigned wlen_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 24;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/srx_sync_edge.sv
module srx_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync_i,
    output logic start_o
);
    typedef struct packed {
        logic prev;
    } edge_reg_t;

    edge_reg_t d, q;

    always_comb begin
        d      = q;
        d.prev = fsync_i;
    end

    assign start_o = fsync_i & ~q.prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int WMAX   = 32,
    parameter int NWORDS = 6,
    parameter int IDXW   = $clog2(NWORDS),
    parameter int CNTW   = $clog2(WMAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            mode_b_i,
    input  logic [1:0]      wlen_i,
    input  logic            sdata_i,
    output logic            word_vld_o,
    output logic [IDXW-1:0] word_idx_o,
    output logic [WMAX-1:0] word_o,
    output logic            err_o
);
    typedef struct packed {
        srx_state_e      state;
        logic [CNTW-1:0] cnt;
        logic [IDXW-1:0] idx;
        logic [WMAX-1:0] shift;
        logic            err;
    } frm_reg_t;

    frm_reg_t d, q;

    logic [CNTW-1:0] len;
    logic [CNTW-1:0] cnt_e;
    logic [IDXW-1:0] idx_e;
    logic [WMAX-1:0] shift_n;
    logic            capture;

    always_comb begin
        d          = q;
        word_vld_o = 1'b0;
        word_idx_o = q.idx;
        word_o     = '0;
        len        = CNTW'(wlen_bits(wlen_i));
        cnt_e      = q.cnt;
        idx_e      = q.idx;
        capture    = 1'b0;
        shift_n    = {q.shift[WMAX-2:0], sdata_i};

        if (start_i) begin
            if (q.state != ST_IDLE) d.err = 1'b1;
            cnt_e = '0;
            idx_e = '0;
            if (mode_b_i) begin
                capture = 1'b1;
            end else begin
                d.state = ST_ARMED;
                d.cnt   = '0;
                d.idx   = '0;
            end
        end else if (q.state != ST_IDLE) begin
            capture = 1'b1;
        end

        if (capture) begin
            d.shift = shift_n;
            if (cnt_e == len - CNTW'(1)) begin
                word_vld_o = 1'b1;
                word_idx_o = idx_e;
                word_o     = shift_n << (WMAX - int'(len));
                d.cnt      = '0;
                if (idx_e == IDXW'(NWORDS - 1)) begin
                    d.state = ST_IDLE;
                    d.idx   = '0;
                end else begin
                    d.state = ST_RECV;
                    d.idx   = idx_e + IDXW'(1);
                end
            end else begin
                d.state = ST_RECV;
                d.cnt   = cnt_e + CNTW'(1);
                d.idx   = idx_e;
            end
        end
    end

    assign err_o = q.err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_IDLE, default: '0};
        else        q <= d;
    end
endmodule

// File: rtl/srx_word_bank.sv
module srx_word_bank #(
    parameter int WMAX   = 32,
    parameter int NWORDS = 6,
    parameter int IDXW   = $clog2(NWORDS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   word_vld_i,
    input  logic [IDXW-1:0]        word_idx_i,
    input  logic [WMAX-1:0]        word_i,
    output logic [NWORDS*WMAX-1:0] words_o,
    output logic                   frame_vld_o
);
    typedef struct packed {
        logic [NWORDS-1:0][WMAX-1:0] stage;
        logic [NWORDS-1:0][WMAX-1:0] out;
        logic                        valid;
    } bank_reg_t;

    bank_reg_t d, q;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (word_vld_i) begin
            d.stage[word_idx_i] = word_i;
            if (word_idx_i == IDXW'(NWORDS - 1)) begin
                d.out   = d.stage;
                d.valid = 1'b1;
            end
        end
    end

    for (genvar k = 0; k < NWORDS; k++) begin : g_slot
        assign words_o[k*WMAX +: WMAX] = q.out[k];
    end

    assign frame_vld_o = q.valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/srx_dsp_rx.sv
module srx_dsp_rx #(
    parameter int WMAX      = 32,
    parameter int NUM_PAIRS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_mode_b_i,
    input  logic [1:0]               cfg_wlen_i,
    input  logic                     fsync_i,
    input  logic                     sdata_i,
    output logic [2*NUM_PAIRS*WMAX-1:0] words_o,
    output logic                     frame_vld_o,
    output logic                     sync_err_o
);
    localparam int NWORDS = 2 * NUM_PAIRS;
    localparam int IDXW   = $clog2(NWORDS);
    localparam int CNTW   = $clog2(WMAX + 1);

    logic            start;
    logic            word_vld;
    logic [IDXW-1:0] word_idx;
    logic [WMAX-1:0] word;

    srx_sync_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .fsync_i (fsync_i),
        .start_o (start)
    );

    srx_framer #(
        .WMAX   (WMAX),
        .NWORDS (NWORDS),
        .IDXW   (IDXW),
        .CNTW   (CNTW)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .mode_b_i   (cfg_mode_b_i),
        .wlen_i     (cfg_wlen_i),
        .sdata_i    (sdata_i),
        .word_vld_o (word_vld),
        .word_idx_o (word_idx),
        .word_o     (word),
        .err_o      (sync_err_o)
    );

    srx_word_bank #(
        .WMAX   (WMAX),
        .NWORDS (NWORDS),
        .IDXW   (IDXW)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_vld_i  (word_vld),
        .word_idx_i  (word_idx),
        .word_i      (word),
        .words_o     (words_o),
        .frame_vld_o (frame_vld_o)
    );
endmodule

// File: rtl/srx_dsp_rx_chk.sv
module srx_dsp_rx_chk #(
    parameter int WORDS_W = 192
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fsync_i,
    input logic [WORDS_W-1:0] words_o,
    input logic               frame_vld_o,
    input logic               sync_err_o
);
    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld_o |=> !frame_vld_o);

    // R7
    words_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(words_o) |-> frame_vld_o);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err_o |=> sync_err_o);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_err_o) |-> $past(fsync_i));
endmodule

bind srx_dsp_rx srx_dsp_rx_chk #(.WORDS_W(NWORDS * WMAX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsync_i     (fsync_i),
    .words_o     (words_o),
    .frame_vld_o (frame_vld_o),
    .sync_err_o  (sync_err_o)
);

// File: tb/srx_dsp_rx_test.sv
`timescale 1ns/1ps
module srx_dsp_rx_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_mode_b_i = 1'b0;
    logic [1:0]   cfg_wlen_i = 2'd0;
    logic         fsync_i = 1'b0;
    logic         sdata_i = 1'b0;
    logic [191:0] words_o;
    logic         frame_vld_o;
    logic         sync_err_o;

    always #2.5 clk = ~clk;

    srx_dsp_rx uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_mode_b_i (cfg_mode_b_i),
        .cfg_wlen_i   (cfg_wlen_i),
        .fsync_i      (fsync_i),
        .sdata_i      (sdata_i),
        .words_o      (words_o),
        .frame_vld_o  (frame_vld_o),
        .sync_err_o   (sync_err_o)
    );

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    // {mode_b, wlen code, seed, trailing junk bits}
    localparam logic [42:0] VEC [6] = '{
        {1'b1, 2'd0, 32'hA5C3_1E77, 8'd4},
        {1'b0, 2'd0, 32'h1357_9BDF, 8'd3},
        {1'b1, 2'd1, 32'hFFFF_0001, 8'd6},
        {1'b0, 2'd2, 32'h8000_7FFE, 8'd5},
        {1'b1, 2'd3, 32'hDEAD_BEEF, 8'd2},
        {1'b0, 2'd3, 32'h0F1E_2D3C, 8'd7}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int lenof(input logic [1:0] c);
        case (c)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] gen(input logic [31:0] seed, input int k);
        return (seed * 32'(k + 3)) ^ (32'h1F2E_3D4C << k) ^ (32'(k) << 28);
    endfunction

    function automatic logic [31:0] expw(input logic [31:0] w, input int len);
        logic [63:0] m;
        logic [63:0] t;
        m = (64'd1 << len) - 64'd1;
        t = (({32'h0, w}) & m) << (32 - len);
        return t[31:0];
    endfunction

    function automatic logic sbit(input logic [31:0] seed, input int len, input int i);
        logic [31:0] w;
        w = gen(seed, i / len);
        return w[len - 1 - (i % len)];
    endfunction

    task automatic junk();
        lfsr    = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sdata_i = lfsr[0];
    endtask

    // Sends the sync and up to nmax bits, ends at the negedge after the last bit's edge.
    task automatic send(input bit mb, input logic [1:0] wl, input logic [31:0] seed,
                        input int nmax, output bit saw_vld);
        int len;
        int total;
        int i;
        len     = lenof(wl);
        total   = (6 * len < nmax) ? 6 * len : nmax;
        saw_vld = 1'b0;
        @(negedge clk);
        cfg_mode_b_i = mb;
        cfg_wlen_i   = wl;
        @(negedge clk);
        fsync_i = 1'b1;
        i = 0;
        if (mb) begin
            sdata_i = sbit(seed, len, 0);
            i = 1;
        end else begin
            sdata_i = ~sbit(seed, len, 0);
        end
        while (i < total) begin
            @(negedge clk);
            if (frame_vld_o) saw_vld = 1'b1;
            fsync_i = 1'b0;
            sdata_i = sbit(seed, len, i);
            i++;
        end
        @(negedge clk);
        fsync_i = 1'b0;
        junk();
    endtask

    task automatic full_frame(input bit mb, input logic [1:0] wl, input logic [31:0] seed,
                              input int gap);
        bit saw;
        int len;
        logic [191:0] snap;
        string mtag;
        len  = lenof(wl);
        mtag = mb ? "R4" : "R5";
        send(mb, wl, seed, 1000, saw);
        chk("R6 no strobe during reception", 64'(saw), 64'd0);
        chk("R6 strobe after last bit", 64'(frame_vld_o), 64'd1);
        for (int k = 0; k < 6; k++) begin
            chk($sformatf("R2 R3 %s slot %0d len %0d", mtag, k, len),
                64'(words_o[k*32 +: 32]), 64'(expw(gen(seed, k), len)));
        end
        @(negedge clk);
        junk();
        chk("R6 strobe one cycle", 64'(frame_vld_o), 64'd0);
        snap = words_o;
        saw  = 1'b0;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            if (frame_vld_o) saw = 1'b1;
            junk();
        end
        @(negedge clk);
        chk("R7 trailing bits raise no strobe", 64'(saw | frame_vld_o), 64'd0);
        chk("R7 slots hold low half", snap[63:0] ^ words_o[63:0], 64'd0);
        chk("R7 slots hold high part", 64'(snap[191:64] != words_o[191:64]), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R6: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit saw;
        repeat (3) @(negedge clk);
        chk("R1 strobe in reset", 64'(frame_vld_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strobe after reset", 64'(frame_vld_o), 64'd0);
        chk("R1 error after reset", 64'(sync_err_o), 64'd0);
        chk("R1 slots after reset", 64'(words_o != '0), 64'd0);

        for (int v = 0; v < 6; v++) begin
            full_frame(VEC[v][42], VEC[v][41:40], VEC[v][39:8], int'(VEC[v][7:0]));
            chk("R9 no error on clean frames", 64'(sync_err_o), 64'd0);
        end

        // R8: early sync in mode B, mid word 3
        send(1'b1, 2'd0, 32'h7777_1111, 50, saw);
        chk("R8 partial frame not published", 64'(saw | frame_vld_o), 64'd0);
        full_frame(1'b1, 2'd0, 32'h2468_ACE0, 3);
        chk("R8 error set by early sync", 64'(sync_err_o), 64'd1);

        // R8: early sync in mode A during word 0
        send(1'b0, 2'd2, 32'h5555_AAAA, 10, saw);
        chk("R8 partial mode A not published", 64'(saw | frame_vld_o), 64'd0);
        full_frame(1'b0, 2'd2, 32'h0BAD_F00D, 4);

        // R9
        chk("R9 error stays after clean frames", 64'(sync_err_o), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears error", 64'(sync_err_o), 64'd0);
        chk("R1 reset clears slots", 64'(words_o != '0), 64'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule